// File: doc/BRIEF.md
# Buffered Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on a line that rests high. A single holding register sits in front of the frame shift register. Software-side logic can write the next character while the current frame is still leaving the block. The transmitter then starts that character in the same bit period in which the previous frame's final stop bit ends, so consecutive frames follow with no idle time between them. Bit timing comes from an external one-cycle enable pulse that marks each bit period. The block never changes the line except on a clock edge where that pulse is high.

The frame shape is picked at run time. The character can be 5 to 9 data bits long. Parity can be off, even or odd, and the frame ends with one or two stop bits. The block has two status flags. One reports that the holding register can accept a character. The other reports that the line has fallen silent after the last queued frame. Each flag drives an interrupt request, gated by its own enable input. The completion flag is cleared either by a clear strobe or by an interrupt acknowledge.

Top module: `frame_tx`

## Requirements
- R1: A frame on `tx_line` is a low start bit, then the data bits least significant first, then the parity bit if parity is on, then the high stop bits. Between frames the line is high.
- R2: `data_bits_cfg` gives the number of data bits from 5 to 9. A value below 5 is treated as 5 and a value above 9 is treated as 9. `parity_cfg` 2'b10 selects even parity, 2'b11 selects odd parity, and 2'b00 or 2'b01 selects no parity. `two_stop`=1 sends two stop bits. All 30 combinations work.
- R3: With even parity the parity bit is the XOR of the sent data bits. With odd parity it is that XOR inverted.
- R4: A held character enters the shifter on the first `bit_en` cycle in which the shifter is idle, or on the `bit_en` cycle that ends the last stop bit. In the second case its start bit follows with no idle bit period.
- R5: While enabled, `buf_empty` is 1 when no character is held. It is 0 from the cycle after a write until the character enters the shifter.
- R6: `tx_done` rises on the `bit_en` cycle that ends a frame's last stop bit, but only if no character is held. It stays 0 when a held frame follows directly.
- R7: `tx_done` is cleared by `done_clr` or by `done_irq_ack`. If a completion event falls in the same cycle, setting the flag takes priority.
- R8: `empty_irq` is `buf_empty` AND `empty_irq_en`. `done_irq` is `tx_done` AND `done_irq_en`.
- R9: While `tx_enable` is 0, the line is high from the next cycle. Any frame in progress and any held character are dropped. `buf_empty` reads 1, and writes are ignored.
- R10: A write while a character is already held replaces that character. The later value is the one sent.
- R11: While enabled, `tx_line` changes only in the cycle after a `bit_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmitter enable |
| data_bits_cfg | input | 4 | Data bit count, 5 to 9 |
| parity_cfg | input | 2 | Parity mode (10 even, 11 odd, else none) |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| done_clr | input | 1 | Clears the completion flag |
| empty_irq_en | input | 1 | Enables the buffer-empty request |
| done_irq_en | input | 1 | Enables the completion request |
| done_irq_ack | input | 1 | Acknowledge of the completion request; clears the flag |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Completion flag |
| empty_irq | output | 1 | Buffer-empty interrupt request |
| done_irq | output | 1 | Completion interrupt request |

## Verification
The frame builder is swept over all 30 shape combinations, with two complementary characters for each, and every bit period is compared to a frame computed arithmetically. This shows up bit-order, parity-sense and stop-count faults that a single pattern could hide. Out-of-range length codes check the clamping. A second character written during a frame shows that the next start bit follows at once and that no completion flag appears. A third write checks that the held value is overwritten. Dropping the enable in mid-frame and writing while disabled show that the line goes high, the buffer is flushed and writes have no effect.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
   typedef enum logic [1:0] {
      PAR_NONE  = 2'b00,
      PAR_NONE1 = 2'b01,
      PAR_EVEN  = 2'b10,
      PAR_ODD   = 2'b11
   } par_mode_e;

   localparam int MIN_DATA_BITS = 5;
endpackage

// File: rtl/ftx_holdbuf.sv
module ftx_holdbuf #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (!enable) begin
         valid <= 1'b0;
      end else if (wr_stb) begin
         // a write wins over a same-cycle transfer: the shifter takes the old value
         data  <= wr_data;
         valid <= 1'b1;
      end else if (take) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ftx_framer.sv
module ftx_framer
   import ftx_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter bit PARITY_EN = 1'b1,
   parameter int LEN_W     = 4,
   parameter int FRAME_W   = DATA_W + 4,
   parameter int CNT_W     = 4
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [LEN_W-1:0]   len_cfg,
   input  logic [1:0]         par_cfg,
   input  logic               two_stop,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   logic par_on;
   logic par_odd;

   generate
      if (PARITY_EN) begin : g_par
         par_mode_e mode;
         assign mode    = par_mode_e'(par_cfg);
         assign par_on  = (mode == PAR_EVEN) || (mode == PAR_ODD);
         assign par_odd = (mode == PAR_ODD);
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign par_odd = 1'b0;
      end
   endgenerate

   always_comb begin
      int   lc;
      int   n;
      logic acc;
      lc = int'(len_cfg);
      if (lc < MIN_DATA_BITS)  n = MIN_DATA_BITS;
      else if (lc > DATA_W)    n = DATA_W;
      else                     n = lc;
      frame    = '1;
      frame[0] = 1'b0;
      acc      = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < n) begin
            frame[i+1] = data[i];
            acc        = acc ^ data[i];
         end
      end
      if (par_on) frame[n+1] = acc ^ par_odd;
      nbits = CNT_W'(n + 2 + (par_on ? 1 : 0) + (two_stop ? 1 : 0));
   end
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
   parameter int FRAME_W = 13,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               bit_en,
   input  logic               have_data,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               take,
   output logic               finish,
   output logic               line
);
   logic               busy;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   cnt;
   logic               last;

   assign last   = busy && (cnt == CNT_W'(1));
   assign take   = enable && bit_en && have_data && (!busy || last);
   assign finish = enable && bit_en && last;
   assign line   = busy ? sr[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sr   <= '1;
         cnt  <= '0;
      end else if (!enable) begin
         busy <= 1'b0;
         sr   <= '1;
         cnt  <= '0;
      end else if (bit_en) begin
         if (take) begin
            sr   <= frame;
            cnt  <= nbits;
            busy <= 1'b1;
         end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy) begin
            sr  <= {1'b1, sr[FRAME_W-1:1]};
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ftx_status.sv
module ftx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic valid,
   input  logic finish,
   input  logic take,
   input  logic done_clr,
   input  logic done_ack,
   input  logic empty_en,
   input  logic done_en,
   output logic buf_empty,
   output logic tx_done,
   output logic empty_irq,
   output logic done_irq
);
   logic set_done;

   assign set_done  = finish && !take;
   assign buf_empty = !valid || !enable;
   assign empty_irq = buf_empty && empty_en;
   assign done_irq  = tx_done && done_en;

   always_ff @(posedge clk) begin
      if (!rst_n)                    tx_done <= 1'b0;
      else if (set_done)             tx_done <= 1'b1;
      else if (done_clr || done_ack) tx_done <= 1'b0;
   end
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
   parameter int DATA_W    = 9,
   parameter bit PARITY_EN = 1'b1,
   parameter int LEN_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              tx_enable,
   input  logic [LEN_W-1:0]  data_bits_cfg,
   input  logic [1:0]        parity_cfg,
   input  logic              two_stop,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done_clr,
   input  logic              empty_irq_en,
   input  logic              done_irq_en,
   input  logic              done_irq_ack,
   output logic              tx_line,
   output logic              buf_empty,
   output logic              tx_done,
   output logic              empty_irq,
   output logic              done_irq
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("frame_tx: DATA_W must lie in 5..9");
      end
      if ((1 << LEN_W) <= DATA_W) begin : g_bad_len
         $error("frame_tx: LEN_W too narrow for DATA_W");
      end
   endgenerate

   logic              hb_valid;
   logic [DATA_W-1:0] hb_data;
   logic              take;
   logic              finish;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;

   ftx_holdbuf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .enable(tx_enable),
      .wr_stb(wr_stb), .wr_data(wr_data), .take(take),
      .valid(hb_valid), .data(hb_data)
   );

   ftx_framer #(
      .DATA_W(DATA_W), .PARITY_EN(PARITY_EN), .LEN_W(LEN_W),
      .FRAME_W(FRAME_W), .CNT_W(CNT_W)
   ) u_frm (
      .data(hb_data), .len_cfg(data_bits_cfg), .par_cfg(parity_cfg),
      .two_stop(two_stop), .frame(frame), .nbits(nbits)
   );

   ftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .enable(tx_enable), .bit_en(bit_en),
      .have_data(hb_valid), .frame(frame), .nbits(nbits),
      .take(take), .finish(finish), .line(tx_line)
   );

   ftx_status u_st (
      .clk(clk), .rst_n(rst_n), .enable(tx_enable), .valid(hb_valid),
      .finish(finish), .take(take), .done_clr(done_clr),
      .done_ack(done_irq_ack), .empty_en(empty_irq_en),
      .done_en(done_irq_en), .buf_empty(buf_empty), .tx_done(tx_done),
      .empty_irq(empty_irq), .done_irq(done_irq)
   );
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic tx_enable,
   input logic wr_stb,
   input logic done_clr,
   input logic done_irq_ack,
   input logic tx_line,
   input logic buf_empty,
   input logic tx_done
);
   // R11
   line_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bit_en) && $past(tx_enable) && tx_enable) |-> $stable(tx_line));

   // R5
   write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && tx_enable) ##1 tx_enable |-> !buf_empty);

   // R6
   done_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> tx_line);

   // R7
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_clr || done_irq_ack) && !bit_en) |=> !tx_done);

   // R9
   disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> tx_line);
endmodule

bind frame_tx ftx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
   .wr_stb(wr_stb), .done_clr(done_clr), .done_irq_ack(done_irq_ack),
   .tx_line(tx_line), .buf_empty(buf_empty), .tx_done(tx_done)
);

// File: tb/tb_frame_tx.sv
module tb_frame_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       tx_enable = 1'b1;
   logic [3:0] data_bits_cfg = 4'd8;
   logic [1:0] parity_cfg = 2'b00;
   logic       two_stop = 1'b0;
   logic       wr_stb = 1'b0;
   logic [8:0] wr_data = '0;
   logic       done_clr = 1'b0;
   logic       empty_irq_en = 1'b0;
   logic       done_irq_en = 1'b0;
   logic       done_irq_ack = 1'b0;
   logic       tx_line, buf_empty, tx_done, empty_irq, done_irq;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   frame_tx dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
      .data_bits_cfg(data_bits_cfg), .parity_cfg(parity_cfg), .two_stop(two_stop),
      .wr_stb(wr_stb), .wr_data(wr_data), .done_clr(done_clr),
      .empty_irq_en(empty_irq_en), .done_irq_en(done_irq_en),
      .done_irq_ack(done_irq_ack), .tx_line(tx_line), .buf_empty(buf_empty),
      .tx_done(tx_done), .empty_irq(empty_irq), .done_irq(done_irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(int n, int par, int two);
      return 2 + n + ((par >= 2) ? 1 : 0) + two;
   endfunction

   function automatic int exp_bit(int d, int n, int par, int two, int k);
      int ones = 0;
      for (int i = 0; i < n; i++) ones += (d >> i) & 1;
      if (k == 0) return 0;
      if (k <= n) return (d >> (k - 1)) & 1;
      if (par >= 2 && k == n + 1) return (par == 3) ? 1 - (ones % 2) : ones % 2;
      return 1;
   endfunction

   task automatic tick();
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic wr(input int d);
      wr_stb  = 1'b1;
      wr_data = 9'(d);
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic pulse_clr();
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
   endtask

   // shifts out bits from..L-1 and returns captured and expected bit vectors
   task automatic shift_bits(input int d, n, par, two, from, output int cap, output int expv);
      cap = 0; expv = 0;
      for (int k = from; k < exp_len(n, par, two); k++) begin
         tick();
         cap  |= int'(tx_line) << k;
         expv |= exp_bit(d, n, par, two, k) << k;
      end
   endtask

   task automatic one_frame(input int d, cfg_n, n, par, two, input string req);
      int cap, expv;
      data_bits_cfg = 4'(cfg_n);
      parity_cfg    = 2'(par);
      two_stop      = 1'(two);
      wr(d);
      shift_bits(d, n, par, two, 0, cap, expv);
      chk(cap == expv, req, cap, expv);
      tick();
      chk(tx_line && tx_done, "R6 done after last stop", {tx_line, tx_done}, 3);
      pulse_clr();
      chk(!tx_done, "R7 clear strobe", tx_done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cap, expv;
      int a, b, c;
      repeat (3) @(negedge clk);
      chk(tx_line && buf_empty && !tx_done, "reset R1 R5", {tx_line, buf_empty, tx_done}, 6);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: full sweep of frame shapes, two characters each
      for (int n = 5; n <= 9; n++)
         for (int par = 0; par < 4; par++)
            for (int two = 0; two < 2; two++) begin
               a = (n * 37 + par * 11 + two * 5 + 3) & 9'h1ff;
               one_frame(a, n, n, par, two, "R1 R2 R3 frame");
               one_frame(a ^ 9'h1ff, n, n, par, two, "R1 R2 R3 frame inv");
            end

      // R2: clamping of out-of-range length codes
      one_frame(9'h0b5, 2, 5, 2, 0, "R2 clamp low");
      one_frame(9'h1a6, 15, 9, 3, 1, "R2 clamp high");

      // R4 R5 R6 R11: back-to-back frames, 8N1
      data_bits_cfg = 4'd8; parity_cfg = 2'b00; two_stop = 1'b0;
      a = 9'h0c3; b = 9'h05a;
      wr(a);
      chk(!buf_empty, "R5 full after write", buf_empty, 0);
      tick();
      chk(!tx_line && buf_empty, "R4 R5 load on tick", {tx_line, buf_empty}, 1);
      repeat (3) @(negedge clk);
      chk(!tx_line, "R11 line holds between ticks", tx_line, 0);
      wr(b);
      chk(!buf_empty, "R5 full while shifting", buf_empty, 0);
      shift_bits(a, 8, 0, 0, 1, cap, expv);
      chk(cap == expv, "R4 first frame", cap, expv);
      tick();
      chk(!tx_line && !tx_done, "R4 R6 gapless start", {tx_line, tx_done}, 0);
      shift_bits(b, 8, 0, 0, 1, cap, expv);
      chk(cap == expv, "R4 second frame", cap, expv);
      tick();
      chk(tx_line && tx_done, "R6 done after queue drains", {tx_line, tx_done}, 3);

      // R8: interrupt gating
      chk(!done_irq && !empty_irq, "R8 requests masked", {done_irq, empty_irq}, 0);
      done_irq_en = 1'b1; empty_irq_en = 1'b1;
      @(negedge clk);
      chk(done_irq && empty_irq, "R8 requests enabled", {done_irq, empty_irq}, 3);
      wr(9'h011);
      chk(!empty_irq, "R8 empty request drops on write", empty_irq, 0);
      // R7: acknowledge clears completion
      done_irq_ack = 1'b1;
      @(negedge clk);
      done_irq_ack = 1'b0;
      chk(!tx_done && !done_irq, "R7 acknowledge clears", {tx_done, done_irq}, 0);
      shift_bits(9'h011, 8, 0, 0, 0, cap, expv);
      tick();
      pulse_clr();
      done_irq_en = 1'b0; empty_irq_en = 1'b0;

      // R10: overwrite of a held character
      a = 9'h0f0; b = 9'h033; c = 9'h0a5;
      wr(a);
      tick();
      wr(b);
      wr(c);
      shift_bits(a, 8, 0, 0, 1, cap, expv);
      shift_bits(c, 8, 0, 0, 0, cap, expv);
      chk(cap == expv, "R10 latest value sent", cap, expv);
      tick();
      pulse_clr();

      // R9: disable mid-frame with a held character
      a = 9'h000; b = 9'h0ff;
      wr(a);
      tick(); tick();
      wr(b);
      chk(!tx_line, "R9 mid-frame low bit", tx_line, 0);
      tx_enable = 1'b0;
      @(negedge clk);
      chk(tx_line && buf_empty, "R9 idle when disabled", {tx_line, buf_empty}, 3);
      wr(9'h000);
      chk(buf_empty, "R9 write ignored while disabled", buf_empty, 1);
      tx_enable = 1'b1;
      @(negedge clk);
      chk(buf_empty, "R9 buffer flushed", buf_empty, 1);
      cap = 0;
      for (int k = 0; k < 12; k++) begin
         tick();
         cap |= int'(!tx_line);
      end
      chk(cap == 0 && !tx_done, "R9 no frame after re-enable", {cap[0], tx_done}, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule